// File: doc/BRIEF.md
# Dual-Port Special Function Register Overlay

This block sits beside a two-port shared memory and takes over its two lowest addresses when the active-low special-function enable `sfen_n` is low. Address 0 then becomes a read-only view of two external status pins, which pass through a two-flop synchronizer. Address 1 becomes a 5-bit output drive register. Each bit of that register switches one external device on (1) or off (0). Both ports can write the drive register and read it back. Every write to it is also passed on to memory location 1, so the memory keeps a mirror copy. While `sfen_n` is high, both addresses are ordinary memory and the drive outputs are forced off.

Each port has the usual active-low strobes (chip enable, write enable, output enable, lower and upper byte selects), an address, and the low five bits of its write data. An access is taken on every rising clock edge at which the port's chip enable is low. For each port the block produces a memory write enable. For a register read it also produces a select and the register data, both registered and valid in the cycle after the access, which is the same cycle the memory read data arrives. Every control pin is a plain level signal. The block has no handshake and no back-pressure: it accepts one access per port per cycle.

Top module: `sfr_dual_port`

## Requirements
- R1: With `sfen_n` low, a read (write enable high) of address 0 sets `x_reg_sel` in the next cycle. If the lower byte select and output enable were both low during that read, `x_reg_rdata` then carries the synchronized inputs on bits 1:0 and zeros on bits 15:2.
- R2: With `sfen_n` low, a write to address 0 from either port drives that port's `x_mem_we` low and changes no register.
- R3: With `sfen_n` low, a write to address 1 with the lower byte select low loads bits 4:0 of the write data into the drive register at that clock edge. A read of address 1 returns the register on bits 4:0 and zeros on bits 15:5.
- R4: A write to address 1 that updates the drive register also raises that port's `x_mem_we` in the same cycle. In general `x_mem_we` is high exactly when chip enable and write enable are low, at least one byte select is low, and the access is not a blocked address-0 write.
- R5: With `sfen_n` high, addresses 0 and 1 are ordinary memory: `x_reg_sel` stays low, the drive register does not change, and `drv_on` is all zeros. With `sfen_n` low, `drv_on` equals the drive register.
- R6: Register read data is valid only when the lower byte select and output enable were both low. Otherwise `x_reg_rdata` is zero. When `x_reg_sel` is low, `x_reg_rdata` is zero.
- R7: A change on `ext_in` first appears in a read of address 0 taken at the third rising edge after the change; reads at the first and second edges still return the old value.
- R8: While reset is asserted, and after it is released, the drive register is zero, and `x_reg_sel` and `x_reg_rdata` are zero until the first register read.
- R9: If both ports write the drive register at the same edge, the left port's data is kept.
- R10: A read of address 1 at the same edge as a write to it from the other port returns the value held before that edge. A read at the next edge returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfen_n | input | 1 | Special-function enable, low = registers overlay addresses 0 and 1 |
| ext_in | input | 2 | External status inputs (asynchronous) |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_lb_n | input | 1 | Left lower byte select, active low |
| l_ub_n | input | 1 | Left upper byte select, active low |
| l_addr | input | 14 | Left address |
| l_wdata_lo | input | 5 | Left write data bits 4:0 |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_lb_n | input | 1 | Right lower byte select, active low |
| r_ub_n | input | 1 | Right upper byte select, active low |
| r_addr | input | 14 | Right address |
| r_wdata_lo | input | 5 | Right write data bits 4:0 |
| l_mem_we | output | 1 | Left write enable toward the memory array |
| l_reg_sel | output | 1 | Left read data comes from a register (one cycle after access) |
| l_reg_rdata | output | 16 | Left register read data |
| r_mem_we | output | 1 | Right write enable toward the memory array |
| r_reg_sel | output | 1 | Right read data comes from a register |
| r_reg_rdata | output | 16 | Right register read data |
| drv_on | output | 5 | Drive enables for the external devices, 1 = on |

## Verification
The drive register can be hit by both ports in one cycle, in two ways. Both ports can write it together, and then the left data must survive. Or one port can read it while the other writes it, and then the read must return the old value and only the next read the new one. Directed cycles set up each case with known data, and a constrained-random run makes both ports access addresses 0 to 3 in the same cycles. A bench model, updated at each clock edge from the requirements, gives the expected register value, synchronizer contents and per-port outputs.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  // Active-high view of one port's strobes
  typedef struct packed {
    logic sel;   // chip enabled
    logic wr;    // write access
    logic oe;    // output enabled
    logic lb;    // lower byte lane
    logic ub;    // upper byte lane
  } sfr_ctl_t;

  localparam int unsigned SFR_IN_ADDR  = 0;
  localparam int unsigned SFR_DRV_ADDR = 1;
endpackage

// File: rtl/sfr_in_sync.sv
module sfr_in_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= async_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= '0;
      else        st[i] <= st[i-1];
    end
  end

  assign sync_out = st[STAGES-1];

  // R7
  sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out == $past(st[STAGES-2]));
endmodule

// File: rtl/sfr_drive_reg.sv
module sfr_drive_reg #(
  parameter int DRV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sfen_n,
  input  logic             l_wr,
  input  logic [DRV_W-1:0] l_data,
  input  logic             r_wr,
  input  logic [DRV_W-1:0] r_data,
  output logic [DRV_W-1:0] drv_q,
  output logic [DRV_W-1:0] drv_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    drv_q <= '0;
    else if (l_wr) drv_q <= l_data;
    else if (r_wr) drv_q <= r_data;
  end

  assign drv_on = sfen_n ? '0 : drv_q;

  // R9
  left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_wr |=> drv_q == $past(l_data));
  // R3
  right_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_wr && r_wr) |=> drv_q == $past(r_data));
  // R5
  drv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_wr && !r_wr) |=> $stable(drv_q));
  // R5
  drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfen_n |-> drv_on == '0);
endmodule

// File: rtl/sfr_port_decode.sv
module sfr_port_decode
  import sfr_pkg::*;
#(
  parameter int AW    = 14,
  parameter int DW    = 16,
  parameter int IN_W  = 2,
  parameter int DRV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sfr_ctl_t         ctl,
  input  logic [AW-1:0]    addr,
  input  logic             sfen_n,
  input  logic             sf_active,
  input  logic [IN_W-1:0]  in_val,
  input  logic [DRV_W-1:0] drv_val,
  output logic             mem_we,
  output logic             drv_wr,
  output logic             reg_sel,
  output logic [DW-1:0]    reg_rdata
);
  logic          sf_on, hit_in, hit_drv, rd_hit, rd_ok;
  logic [DW-1:0] rd_next;

  assign sf_on   = !sfen_n && sf_active && ctl.sel;
  assign hit_in  = sf_on && (addr == AW'(SFR_IN_ADDR));
  assign hit_drv = sf_on && (addr == AW'(SFR_DRV_ADDR));
  assign rd_hit  = (hit_in || hit_drv) && !ctl.wr;
  assign rd_ok   = rd_hit && ctl.lb && ctl.oe;

  assign mem_we  = ctl.sel && ctl.wr && (ctl.lb || ctl.ub) && !hit_in;
  assign drv_wr  = hit_drv && ctl.wr && ctl.lb;

  always_comb begin
    rd_next = '0;
    if (rd_ok) begin
      if (hit_in) rd_next[IN_W-1:0]  = in_val;
      else        rd_next[DRV_W-1:0] = drv_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_sel   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_sel   <= rd_hit;
      reg_rdata <= rd_next;
    end
  end

  // R2
  in_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sfen_n && ctl.sel && ctl.wr && addr == AW'(SFR_IN_ADDR)) |-> !mem_we);
  // R4
  drv_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_wr |-> mem_we);
  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> reg_rdata == '0);
  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1:DRV_W] == '0);
endmodule

// File: rtl/sfr_dual_port.sv
module sfr_dual_port
  import sfr_pkg::*;
#(
  parameter int AW     = 14,
  parameter int DW     = 16,
  parameter int IN_W   = 2,
  parameter int DRV_W  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sfen_n,
  input  logic [IN_W-1:0]  ext_in,
  input  logic             l_ce_n,
  input  logic             l_we_n,
  input  logic             l_oe_n,
  input  logic             l_lb_n,
  input  logic             l_ub_n,
  input  logic [AW-1:0]    l_addr,
  input  logic [DRV_W-1:0] l_wdata_lo,
  input  logic             r_ce_n,
  input  logic             r_we_n,
  input  logic             r_oe_n,
  input  logic             r_lb_n,
  input  logic             r_ub_n,
  input  logic [AW-1:0]    r_addr,
  input  logic [DRV_W-1:0] r_wdata_lo,
  output logic             l_mem_we,
  output logic             l_reg_sel,
  output logic [DW-1:0]    l_reg_rdata,
  output logic             r_mem_we,
  output logic             r_reg_sel,
  output logic [DW-1:0]    r_reg_rdata,
  output logic [DRV_W-1:0] drv_on
);
  localparam int NPORT = 2;

  sfr_ctl_t         ctl   [NPORT];
  logic [AW-1:0]    addr  [NPORT];
  logic             mwe   [NPORT];
  logic             dwr   [NPORT];
  logic             rsel  [NPORT];
  logic [DW-1:0]    rdat  [NPORT];
  logic [IN_W-1:0]  in_sync;
  logic [DRV_W-1:0] drv_q;
  logic             sf_active;

  assign ctl[0]  = '{sel: !l_ce_n, wr: !l_we_n, oe: !l_oe_n, lb: !l_lb_n, ub: !l_ub_n};
  assign ctl[1]  = '{sel: !r_ce_n, wr: !r_we_n, oe: !r_oe_n, lb: !r_lb_n, ub: !r_ub_n};
  assign addr[0] = l_addr;
  assign addr[1] = r_addr;
  assign sf_active = !l_ce_n || !r_ce_n;

  sfr_in_sync #(.W(IN_W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_in), .sync_out(in_sync));

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    sfr_port_decode #(.AW(AW), .DW(DW), .IN_W(IN_W), .DRV_W(DRV_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .ctl(ctl[p]), .addr(addr[p]),
      .sfen_n(sfen_n), .sf_active(sf_active), .in_val(in_sync),
      .drv_val(drv_q), .mem_we(mwe[p]), .drv_wr(dwr[p]),
      .reg_sel(rsel[p]), .reg_rdata(rdat[p]));
  end

  sfr_drive_reg #(.DRV_W(DRV_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .sfen_n(sfen_n),
    .l_wr(dwr[0]), .l_data(l_wdata_lo),
    .r_wr(dwr[1]), .r_data(r_wdata_lo),
    .drv_q(drv_q), .drv_on(drv_on));

  assign l_mem_we    = mwe[0];
  assign r_mem_we    = mwe[1];
  assign l_reg_sel   = rsel[0];
  assign r_reg_sel   = rsel[1];
  assign l_reg_rdata = rdat[0];
  assign r_reg_rdata = rdat[1];

  // R5
  no_reg_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfen_n && !l_ce_n && l_we_n) |=> !l_reg_sel);
endmodule

// File: tb/tb_sfr_dual_port.sv
module tb_sfr_dual_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, sfen_n = 1;
  logic [1:0] ext_in = 0;
  logic l_ce_n = 1, l_we_n = 1, l_oe_n = 1, l_lb_n = 1, l_ub_n = 1;
  logic r_ce_n = 1, r_we_n = 1, r_oe_n = 1, r_lb_n = 1, r_ub_n = 1;
  logic [13:0] l_addr = 0, r_addr = 0;
  logic [4:0] l_wdata_lo = 0, r_wdata_lo = 0;
  logic l_mem_we, l_reg_sel, r_mem_we, r_reg_sel;
  logic [15:0] l_reg_rdata, r_reg_rdata;
  logic [4:0] drv_on;

  int total = 0, fails = 0;
  logic [4:0] m_drv = 0;
  logic [1:0] m_s1 = 0, m_s2 = 0;

  sfr_dual_port dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic f_we(logic ce_n, we_n, lb_n, ub_n, logic [13:0] a, logic sf_n);
    return !ce_n && !we_n && (!lb_n || !ub_n) && !(!sf_n && a == 0);
  endfunction

  function automatic logic f_sel(logic ce_n, we_n, logic [13:0] a, logic sf_n);
    return !ce_n && we_n && !sf_n && a < 2;
  endfunction

  function automatic logic [15:0] f_rd(logic ce_n, we_n, oe_n, lb_n, logic [13:0] a,
                                       logic sf_n, logic [1:0] s2, logic [4:0] d);
    if (!f_sel(ce_n, we_n, a, sf_n) || lb_n || oe_n) return 16'h0;
    return (a == 0) ? {14'h0, s2} : {11'h0, d};
  endfunction

  function automatic string wtag(logic [13:0] a, logic sf_n);
    if (sf_n) return "R5";
    return (a == 0) ? "R2" : (a == 1) ? "R4" : "R5";
  endfunction

  function automatic string rtag(logic ce_n, we_n, oe_n, lb_n, logic [13:0] a, logic sf_n);
    if (!f_sel(ce_n, we_n, a, sf_n)) return "R5";
    if (lb_n || oe_n) return "R6";
    return (a == 0) ? "R1" : "R3";
  endfunction

  // one access cycle: inputs already driven after a falling edge
  task automatic tick();
    logic esl, esr, lw, rw;
    logic [15:0] edl, edr;
    string tl, tr;
    #1;
    chk(wtag(l_addr, sfen_n), l_mem_we, f_we(l_ce_n, l_we_n, l_lb_n, l_ub_n, l_addr, sfen_n));
    chk(wtag(r_addr, sfen_n), r_mem_we, f_we(r_ce_n, r_we_n, r_lb_n, r_ub_n, r_addr, sfen_n));
    esl = f_sel(l_ce_n, l_we_n, l_addr, sfen_n);
    esr = f_sel(r_ce_n, r_we_n, r_addr, sfen_n);
    edl = f_rd(l_ce_n, l_we_n, l_oe_n, l_lb_n, l_addr, sfen_n, m_s2, m_drv);
    edr = f_rd(r_ce_n, r_we_n, r_oe_n, r_lb_n, r_addr, sfen_n, m_s2, m_drv);
    tl = rtag(l_ce_n, l_we_n, l_oe_n, l_lb_n, l_addr, sfen_n);
    tr = rtag(r_ce_n, r_we_n, r_oe_n, r_lb_n, r_addr, sfen_n);
    lw = !sfen_n && !l_ce_n && !l_we_n && !l_lb_n && l_addr == 1;
    rw = !sfen_n && !r_ce_n && !r_we_n && !r_lb_n && r_addr == 1;
    @(posedge clk);
    m_s2 = m_s1; m_s1 = ext_in;
    if (lw) m_drv = l_wdata_lo;
    else if (rw) m_drv = r_wdata_lo;
    @(negedge clk);
    chk(tl, l_reg_sel, esl);
    chk(tl, l_reg_rdata, edl);
    chk(tr, r_reg_sel, esr);
    chk(tr, r_reg_rdata, edr);
    chk((lw && rw) ? "R9" : "R3", drv_on, sfen_n ? 5'h0 : m_drv);
  endtask

  task automatic idle();
    l_ce_n = 1; l_we_n = 1; l_oe_n = 1; l_lb_n = 1; l_ub_n = 1;
    r_ce_n = 1; r_we_n = 1; r_oe_n = 1; r_lb_n = 1; r_ub_n = 1;
  endtask

  task automatic lacc(logic wr, logic [13:0] a, logic [4:0] d);
    l_ce_n = 0; l_we_n = !wr; l_oe_n = wr; l_lb_n = 0; l_ub_n = 0; l_addr = a; l_wdata_lo = d;
  endtask

  task automatic racc(logic wr, logic [13:0] a, logic [4:0] d);
    r_ce_n = 0; r_we_n = !wr; r_oe_n = wr; r_lb_n = 0; r_ub_n = 0; r_addr = a; r_wdata_lo = d;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8", {l_reg_sel, r_reg_sel, drv_on}, 0);
    chk("R8", l_reg_rdata | r_reg_rdata, 0);
    rst_n = 1;
    sfen_n = 0;
    // R8: after release, register still clear
    idle(); lacc(0, 1, 0); tick();
    chk("R8", l_reg_rdata, 0);

    // R9: both ports write drive register together
    idle(); lacc(1, 1, 5'h15); racc(1, 1, 5'h0A); tick();
    chk("R9", drv_on, 5'h15);

    // R10: right reads while left writes
    idle(); lacc(1, 1, 5'h07); racc(0, 1, 0); tick();
    chk("R10", r_reg_rdata, 16'h0015);
    idle(); racc(0, 1, 0); tick();
    chk("R10", r_reg_rdata, 16'h0007);

    // R2: write to address 0 changes nothing
    idle(); racc(1, 0, 5'h1F); tick();
    chk("R2", drv_on, 5'h07);

    // R7: input change takes three edges to appear
    idle(); ext_in = 2'b10; lacc(0, 0, 0); tick();
    chk("R7", l_reg_rdata, 0);
    idle(); lacc(0, 0, 0); tick();
    chk("R7", l_reg_rdata, 0);
    idle(); lacc(0, 0, 0); tick();
    chk("R7", l_reg_rdata, 16'h0002);

    // R6: read with output enable high or lower lane off
    idle(); lacc(0, 1, 0); l_oe_n = 1; tick();
    chk("R6", {l_reg_sel, l_reg_rdata}, {1'b1, 16'h0});
    idle(); racc(0, 1, 0); r_lb_n = 1; tick();
    chk("R6", {r_reg_sel, r_reg_rdata}, {1'b1, 16'h0});

    // R5: enable off, drive register frozen and outputs off
    sfen_n = 1;
    idle(); lacc(1, 1, 5'h1C); tick();
    chk("R5", drv_on, 0);
    sfen_n = 0;
    idle(); tick();
    chk("R5", drv_on, 5'h07);

    // constrained random mix
    void'($urandom(32'h5F3A));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      sfen_n = (r[3:0] == 0);
      ext_in = r[5:4];
      l_ce_n = r[6]; l_we_n = r[7]; l_oe_n = r[8]; l_lb_n = r[9] & r[10]; l_ub_n = r[11];
      r_ce_n = r[12]; r_we_n = r[13]; r_oe_n = r[14]; r_lb_n = r[15] & r[16]; r_ub_n = r[17];
      l_addr = r[18] ? 14'(r[20:19]) : 14'h3FFF;
      r_addr = r[21] ? 14'(r[23:22]) : 14'h2000;
      l_wdata_lo = r[28:24];
      r_wdata_lo = 5'($urandom);
      tick();
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule